// File: doc/BRIEF.md
# Kernel Launch Control Register Slave

This block sits between a host-facing AXI4-Lite port and a compute core that uses a start/done handshake. The host writes argument words, sets a start request in a control word, and then either polls that word for a completion flag or waits on an active-high interrupt line. The block drives a start level to the core, captures the core's single-cycle done pulse, and presents all argument words to the core as flat vectors.

Offsets below 0x10 hold the control word and three interrupt registers: a global enable, a per-source enable, and a per-source status. Argument words begin at 0x10: first a parameterised number of 32-bit scalars, then a parameterised number of 64-bit pointers. Each pointer takes two consecutive words. The active-low synchronous reset passes through a short register pipeline before it reaches the internal logic.

Top module: `kctl_axil_slave`

## Requirements
- R1: While the internal reset is active, every register reads as zero after reset, core_start and irq are low, no response is pending, and awready, wready and arready are low. After aresetn rises, the ready signals return high on the second rising clock edge.
- R2: The write address and the write data may arrive together or in either order. Each write produces exactly one B response with bresp 0 (OKAY), and bvalid stays high until bready is seen. Each read produces one R response with rresp 0, and rvalid and rdata stay steady until rready is seen.
- R3: Writing the control word (offset 0x00) with bit 0 set and byte strobe 0 set raises core_start. Read bit 0 of the control word returns the start request. Writes to bits 1 and 2 of the control word have no effect.
- R4: core_start falls on the clock edge at which core_done is sampled high.
- R5: Control bit 1 (done) sets on a core_done pulse. A read of offset 0x00 returns the flag and clears it, so a second read returns 0.
- R6: Control bit 2 reads as the current level of the core_idle input.
- R7: Offset 0x04 bit 0 is the global interrupt enable. irq is high exactly when that bit and status bit 0 are both set.
- R8: Offset 0x08 bit 0 enables the done source. Offset 0x0C bit 0 is its status and sets on a core_done pulse only while the enable is set. Writing 1 to status bit 0 inverts it, so writing 1 to a set bit clears it. Reads of 0x04, 0x08 and 0x0C return only bit 0.
- R9: Scalar i is at offset 0x10+4*i. Pointer k has its low word at offset 0x10+4*(N_SCALAR+2*k) and its high word at the next offset. arg_scalar[32*i+:32] and arg_ptr[64*k+:64] show the stored values.
- R10: Each byte lane of a register is written only when its wstrb bit is set. This also applies to the control bits.
- R11: Reads of offsets outside 0x00 to the last argument word return 0. Writes to those offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Clock |
| aresetn | input | 1 | Active-low synchronous reset |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | ADDR_W | Write byte address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | ADDR_W | Read byte address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| core_start | output | 1 | Start request level to the core |
| core_done | input | 1 | Single-cycle completion pulse from the core |
| core_idle | input | 1 | Core idle level |
| irq | output | 1 | Active-high interrupt |
| arg_scalar | output | 32*N_SCALAR | Scalar argument words |
| arg_ptr | output | 64*N_PTR | Pointer arguments |

## Verification
The assertions assume the following:
- core_done is a one-cycle pulse.
- core_done never lands on the same edge as a host write to the control word or to the status register.
- The host holds each valid until it is accepted.

The stimulus respects these assumptions. It raises core_done only between bus transactions, and it raises a valid only when the matching ready is already high. Within those limits it covers all three write-channel orderings, strobe patterns, held responses, and done pulses with each enable combination.

// File: rtl/kctl_pkg.sv
package kctl_pkg;
    localparam int DATA_W      = 32;
    localparam int STRB_W      = DATA_W / 8;
    localparam int CTRL_WORD   = 0;
    localparam int GIE_WORD    = 1;
    localparam int IER_WORD    = 2;
    localparam int ISR_WORD    = 3;
    localparam int ARG_BASE    = 4;
    localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/kctl_rst_pipe.sv
module kctl_rst_pipe #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_in_n,
    output logic rst_out_n
);
    logic [STAGES-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-2:0], 1'b1};
    end

    always_ff @(posedge clk) begin
        if (!rst_in_n) pipe_q <= '0;
        else           pipe_q <= pipe_d;
    end

    assign rst_out_n = pipe_q[STAGES-1];
endmodule

// File: rtl/kctl_wr_chan.sv
module kctl_wr_chan
    import kctl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              awvalid,
    output logic              awready,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              wvalid,
    output logic              wready,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] wstrb,
    output logic              bvalid,
    input  logic              bready,
    output logic [1:0]        bresp,
    output logic              reg_we,
    output logic [ADDR_W-1:0] reg_waddr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic [STRB_W-1:0] reg_wstrb
);
    typedef struct packed {
        logic              aw_full;
        logic [ADDR_W-1:0] addr;
        logic              w_full;
        logic [DATA_W-1:0] data;
        logic [STRB_W-1:0] strb;
        logic              bvalid;
    } wr_state_t;

    wr_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        awready = rst_n && !st_q.aw_full;
        wready  = rst_n && !st_q.w_full;
        reg_we  = st_q.aw_full && st_q.w_full && !st_q.bvalid;
        if (awvalid && awready) begin
            st_d.aw_full = 1'b1;
            st_d.addr    = awaddr;
        end
        if (wvalid && wready) begin
            st_d.w_full = 1'b1;
            st_d.data   = wdata;
            st_d.strb   = wstrb;
        end
        if (reg_we) begin
            st_d.aw_full = 1'b0;
            st_d.w_full  = 1'b0;
            st_d.bvalid  = 1'b1;
        end
        if (st_q.bvalid && bready) st_d.bvalid = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_waddr = st_q.addr;
    assign reg_wdata = st_q.data;
    assign reg_wstrb = st_q.strb;
    assign bvalid    = st_q.bvalid;
    assign bresp     = RESP_OKAY;

    // R2: a pending write response is held until the host takes it
    a_r2_bvalid_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && !bready) |=> bvalid);
endmodule

// File: rtl/kctl_rd_chan.sv
module kctl_rd_chan
    import kctl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arvalid,
    output logic              arready,
    input  logic [ADDR_W-1:0] araddr,
    output logic              rvalid,
    input  logic              rready,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        rresp,
    output logic              reg_re,
    output logic [ADDR_W-1:0] reg_raddr,
    input  logic [DATA_W-1:0] reg_rdata
);
    typedef struct packed {
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
    } rd_state_t;

    rd_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        arready   = rst_n && !st_q.rvalid;
        reg_re    = arvalid && arready;
        reg_raddr = araddr;
        if (reg_re) begin
            st_d.rvalid = 1'b1;
            st_d.rdata  = reg_rdata;
        end
        if (st_q.rvalid && rready) st_d.rvalid = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rvalid = st_q.rvalid;
    assign rdata  = st_q.rdata;
    assign rresp  = RESP_OKAY;

    // R2: read data stays put while the host stalls
    a_r2_rdata_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !rready) |=> (rvalid && $stable(rdata)));
endmodule

// File: rtl/kctl_regfile.sv
module kctl_regfile
    import kctl_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int N_SCALAR = 2,
    parameter int N_PTR    = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [DATA_W-1:0]       wdata,
    input  logic [STRB_W-1:0]       wstrb,
    input  logic                    re,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [DATA_W-1:0]       rdata,
    output logic                    core_start,
    input  logic                    core_done,
    input  logic                    core_idle,
    output logic                    irq,
    output logic [32*N_SCALAR-1:0]  arg_scalar,
    output logic [64*N_PTR-1:0]     arg_ptr
);
    localparam int IDX_W     = ADDR_W - 2;
    localparam int ARG_WORDS = N_SCALAR + 2 * N_PTR;

    typedef struct packed {
        logic                             start;
        logic                             done;
        logic                             gie;
        logic                             ier;
        logic                             isr;
        logic [ARG_WORDS-1:0][DATA_W-1:0] arg;
    } regs_t;

    regs_t rg_d, rg_q;

    logic [IDX_W-1:0] widx, ridx;
    logic             unused_lsb;
    assign widx       = waddr[ADDR_W-1:2];
    assign ridx       = raddr[ADDR_W-1:2];
    assign unused_lsb = ^{waddr[1:0], raddr[1:0]};

    always_comb begin
        rg_d = rg_q;
        // completion event from the core
        if (core_done) begin
            rg_d.start = 1'b0;
            rg_d.done  = 1'b1;
            if (rg_q.ier) rg_d.isr = 1'b1;
        end
        // reading the control word consumes the done flag
        if (re && ridx == IDX_W'(CTRL_WORD) && !core_done) rg_d.done = 1'b0;
        if (we && wstrb[0]) begin
            if (widx == IDX_W'(CTRL_WORD) && wdata[0]) rg_d.start = 1'b1;
            if (widx == IDX_W'(GIE_WORD)) rg_d.gie = wdata[0];
            if (widx == IDX_W'(IER_WORD)) rg_d.ier = wdata[0];
            if (widx == IDX_W'(ISR_WORD) && wdata[0]) rg_d.isr = ~rg_d.isr;
        end
        if (we) begin
            for (int k = 0; k < ARG_WORDS; k++) begin
                if (widx == IDX_W'(ARG_BASE + k)) begin
                    for (int b = 0; b < STRB_W; b++) begin
                        if (wstrb[b]) rg_d.arg[k][b*8 +: 8] = wdata[b*8 +: 8];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        rdata = '0;
        if (ridx == IDX_W'(CTRL_WORD)) rdata[2:0] = {core_idle, rg_q.done, rg_q.start};
        if (ridx == IDX_W'(GIE_WORD))  rdata[0]   = rg_q.gie;
        if (ridx == IDX_W'(IER_WORD))  rdata[0]   = rg_q.ier;
        if (ridx == IDX_W'(ISR_WORD))  rdata[0]   = rg_q.isr;
        for (int k = 0; k < ARG_WORDS; k++) begin
            if (ridx == IDX_W'(ARG_BASE + k)) rdata = rg_q.arg[k];
        end
    end

    assign core_start = rg_q.start;
    assign irq        = rg_q.gie && rg_q.isr;

    for (genvar i = 0; i < N_SCALAR; i++) begin : g_scalar
        assign arg_scalar[32*i +: 32] = rg_q.arg[i];
    end
    for (genvar k = 0; k < N_PTR; k++) begin : g_ptr
        assign arg_ptr[64*k +: 64] = {rg_q.arg[N_SCALAR + 2*k + 1], rg_q.arg[N_SCALAR + 2*k]};
    end

    // R4: completion drops the start request unless the host re-arms it in the same cycle
    a_r4_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (core_done && !(we && widx == IDX_W'(CTRL_WORD))) |=> !core_start);

    // R5: reading the control word without a new completion leaves done clear
    a_r5_done_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (re && ridx == IDX_W'(CTRL_WORD) && !core_done) |=> !rg_q.done);

    // R8: status rises by itself only on an enabled completion
    a_r8_status_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rg_q.isr) && !$past(we)) |-> $past(core_done && rg_q.ier));
endmodule

// File: rtl/kctl_axil_slave.sv
module kctl_axil_slave
    import kctl_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int N_SCALAR   = 2,
    parameter int N_PTR      = 2,
    parameter int RST_STAGES = 2
) (
    input  logic                   aclk,
    input  logic                   aresetn,
    input  logic                   s_awvalid,
    output logic                   s_awready,
    input  logic [ADDR_W-1:0]      s_awaddr,
    input  logic                   s_wvalid,
    output logic                   s_wready,
    input  logic [31:0]            s_wdata,
    input  logic [3:0]             s_wstrb,
    output logic                   s_bvalid,
    input  logic                   s_bready,
    output logic [1:0]             s_bresp,
    input  logic                   s_arvalid,
    output logic                   s_arready,
    input  logic [ADDR_W-1:0]      s_araddr,
    output logic                   s_rvalid,
    input  logic                   s_rready,
    output logic [31:0]            s_rdata,
    output logic [1:0]             s_rresp,
    output logic                   core_start,
    input  logic                   core_done,
    input  logic                   core_idle,
    output logic                   irq,
    output logic [32*N_SCALAR-1:0] arg_scalar,
    output logic [64*N_PTR-1:0]    arg_ptr
);
    logic              rst_n;
    logic              reg_we, reg_re;
    logic [ADDR_W-1:0] reg_waddr, reg_raddr;
    logic [31:0]       reg_wdata, reg_rdata;
    logic [3:0]        reg_wstrb;

    kctl_rst_pipe #(.STAGES(RST_STAGES)) u_rst (
        .clk(aclk), .rst_in_n(aresetn), .rst_out_n(rst_n)
    );

    kctl_wr_chan #(.ADDR_W(ADDR_W)) u_wr (
        .clk(aclk), .rst_n(rst_n),
        .awvalid(s_awvalid), .awready(s_awready), .awaddr(s_awaddr),
        .wvalid(s_wvalid), .wready(s_wready), .wdata(s_wdata), .wstrb(s_wstrb),
        .bvalid(s_bvalid), .bready(s_bready), .bresp(s_bresp),
        .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata), .reg_wstrb(reg_wstrb)
    );

    kctl_rd_chan #(.ADDR_W(ADDR_W)) u_rd (
        .clk(aclk), .rst_n(rst_n),
        .arvalid(s_arvalid), .arready(s_arready), .araddr(s_araddr),
        .rvalid(s_rvalid), .rready(s_rready), .rdata(s_rdata), .rresp(s_rresp),
        .reg_re(reg_re), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata)
    );

    kctl_regfile #(.ADDR_W(ADDR_W), .N_SCALAR(N_SCALAR), .N_PTR(N_PTR)) u_regs (
        .clk(aclk), .rst_n(rst_n),
        .we(reg_we), .waddr(reg_waddr), .wdata(reg_wdata), .wstrb(reg_wstrb),
        .re(reg_re), .raddr(reg_raddr), .rdata(reg_rdata),
        .core_start(core_start), .core_done(core_done), .core_idle(core_idle),
        .irq(irq), .arg_scalar(arg_scalar), .arg_ptr(arg_ptr)
    );
endmodule

// File: tb/kctl_axil_slave_bench.sv
`timescale 1ns/1ps
module kctl_axil_slave_bench;
    localparam int ADDR_W = 8;
    localparam int NS = 2;
    localparam int NP = 2;
    localparam int AW = NS + 2 * NP;

    logic aclk = 1'b0;
    logic aresetn;
    logic s_awvalid, s_awready, s_wvalid, s_wready, s_bvalid, s_bready;
    logic s_arvalid, s_arready, s_rvalid, s_rready;
    logic [ADDR_W-1:0] s_awaddr, s_araddr;
    logic [31:0] s_wdata, s_rdata;
    logic [3:0]  s_wstrb;
    logic [1:0]  s_bresp, s_rresp;
    logic core_start, core_done, core_idle, irq;
    logic [32*NS-1:0] arg_scalar;
    logic [64*NP-1:0] arg_ptr;

    always #10 aclk = ~aclk;

    kctl_axil_slave #(.ADDR_W(ADDR_W), .N_SCALAR(NS), .N_PTR(NP)) u_kctl_axil_slave (.*);

    int checks = 0;
    int errors = 0;
    bit in_reset = 1'b1;
    bit m_start, m_done, m_gie, m_ier, m_isr;
    logic [31:0] m_arg [AW];

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cmp_all();
        check("R3 start level", 64'(core_start), 64'(m_start));
        check("R7 irq level", 64'(irq), 64'(m_gie & m_isr));
        check("R9 scalars", arg_scalar, {m_arg[1], m_arg[0]});
        check("R9 ptr0", arg_ptr[63:0], {m_arg[3], m_arg[2]});
        check("R9 ptr1", arg_ptr[127:64], {m_arg[5], m_arg[4]});
    endtask

    task automatic step();
        @(posedge aclk);
        @(negedge aclk);
        if (!in_reset) cmp_all();
    endtask

    function automatic logic [31:0] model_read(logic [7:0] a);
        int w = a >> 2;
        if (w == 0) return {29'd0, core_idle, m_done, m_start};
        if (w == 1) return 32'(m_gie);
        if (w == 2) return 32'(m_ier);
        if (w == 3) return 32'(m_isr);
        if (w >= 4 && w < 4 + AW) return m_arg[w-4];
        return 32'd0;
    endfunction

    task automatic model_write(logic [7:0] a, logic [31:0] d, logic [3:0] s);
        int w = a >> 2;
        if (s[0]) begin
            if (w == 0 && d[0]) m_start = 1'b1;
            if (w == 1) m_gie = d[0];
            if (w == 2) m_ier = d[0];
            if (w == 3 && d[0]) m_isr = ~m_isr;
        end
        if (w >= 4 && w < 4 + AW)
            for (int b = 0; b < 4; b++)
                if (s[b]) m_arg[w-4][b*8 +: 8] = d[b*8 +: 8];
    endtask

    // order: 0 together, 1 address first, 2 data first
    task automatic axi_write(logic [7:0] a, logic [31:0] d, logic [3:0] s, int order, int hold);
        s_awaddr = a; s_wdata = d; s_wstrb = s;
        if (order == 0) begin
            check("R2 both ready", {s_awready, s_wready}, 2'b11);
            s_awvalid = 1'b1; s_wvalid = 1'b1;
            step();
            s_awvalid = 1'b0; s_wvalid = 1'b0;
        end else if (order == 1) begin
            check("R2 aw ready", 64'(s_awready), 1);
            s_awvalid = 1'b1; step(); s_awvalid = 1'b0;
            check("R2 w ready", 64'(s_wready), 1);
            s_wvalid = 1'b1; step(); s_wvalid = 1'b0;
        end else begin
            check("R2 w ready", 64'(s_wready), 1);
            s_wvalid = 1'b1; step(); s_wvalid = 1'b0;
            check("R2 aw ready", 64'(s_awready), 1);
            s_awvalid = 1'b1; step(); s_awvalid = 1'b0;
        end
        model_write(a, d, s);
        step();
        check("R2 bvalid", 64'(s_bvalid), 1);
        check("R2 bresp okay", 64'(s_bresp), 0);
        for (int h = 0; h < hold; h++) begin
            step();
            check("R2 bvalid held", 64'(s_bvalid), 1);
        end
        s_bready = 1'b1; step(); s_bready = 1'b0;
        check("R2 bvalid cleared", 64'(s_bvalid), 0);
    endtask

    task automatic axi_read(logic [7:0] a, string req, int hold);
        logic [31:0] exp;
        exp = model_read(a);
        check("R2 ar ready", 64'(s_arready), 1);
        s_araddr = a; s_arvalid = 1'b1;
        if ((a >> 2) == 0) m_done = 1'b0;
        step();
        s_arvalid = 1'b0;
        check("R2 rvalid", 64'(s_rvalid), 1);
        check("R2 rresp okay", 64'(s_rresp), 0);
        check(req, s_rdata, exp);
        for (int h = 0; h < hold; h++) begin
            step();
            check("R2 rvalid held", 64'(s_rvalid), 1);
            check("R2 rdata held", s_rdata, exp);
        end
        s_rready = 1'b1; step(); s_rready = 1'b0;
        check("R2 rvalid cleared", 64'(s_rvalid), 0);
    endtask

    task automatic pulse_done();
        core_done = 1'b1;
        m_start = 1'b0; m_done = 1'b1;
        if (m_ier) m_isr = 1'b1;
        step();
        core_done = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge aclk);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        aresetn = 1'b0; core_done = 1'b0; core_idle = 1'b1;
        s_awvalid = 0; s_wvalid = 0; s_bready = 0; s_arvalid = 0; s_rready = 0;
        s_awaddr = '0; s_araddr = '0; s_wdata = '0; s_wstrb = '0;
        m_start = 0; m_done = 0; m_gie = 0; m_ier = 0; m_isr = 0;
        for (int i = 0; i < AW; i++) m_arg[i] = '0;
        repeat (4) step();
        aresetn = 1'b1;
        step();
        check("R1 ready low in reset", {s_awready, s_wready, s_arready}, 3'b000);
        step();
        check("R1 ready after release", {s_awready, s_wready, s_arready}, 3'b111);
        check("R1 no response", {s_bvalid, s_rvalid}, 2'b00);
        check("R1 outputs idle", {core_start, irq}, 2'b00);
        in_reset = 1'b0;
        cmp_all();
        for (int a = 0; a < 4 + AW; a++) axi_read(8'(a*4), "R1 reset value", 0);
        axi_read(8'h00, "R6 idle bit", 0);

        // R9 arguments with all three orderings
        axi_write(8'h10, 32'hA5A5_0001, 4'hF, 0, 0);
        axi_write(8'h14, 32'h1234_5678, 4'hF, 1, 0);
        axi_write(8'h18, 32'hDEAD_BEEF, 4'hF, 2, 2);
        axi_write(8'h1C, 32'h0000_0042, 4'hF, 0, 0);
        axi_write(8'h20, 32'hCAFE_F00D, 4'hF, 1, 0);
        axi_write(8'h24, 32'h8000_0007, 4'hF, 2, 0);
        axi_read(8'h18, "R9 ptr0 low", 0);
        axi_read(8'h24, "R9 ptr1 high", 2);
        // R10 partial strobes
        axi_write(8'h14, 32'hFFFF_FFFF, 4'b0101, 0, 0);
        axi_read(8'h14, "R10 strobe lanes", 0);
        axi_write(8'h20, 32'h1111_2222, 4'b1000, 1, 0);
        axi_read(8'h20, "R10 top lane", 0);
        axi_write(8'h00, 32'h1, 4'b0000, 0, 0);
        check("R10 no strobe no start", 64'(core_start), 0);
        // R11 unmapped
        axi_write(8'h28, 32'hFFFF_FFFF, 4'hF, 0, 0);
        axi_write(8'hFC, 32'hFFFF_FFFF, 4'hF, 2, 0);
        axi_read(8'h28, "R11 unmapped read", 0);
        axi_read(8'hFC, "R11 top unmapped read", 0);
        axi_read(8'h10, "R11 args untouched", 0);
        // R3 read-only bits
        axi_write(8'h00, 32'h6, 4'hF, 0, 0);
        axi_read(8'h00, "R3 read-only bits", 0);
        // R3 start
        axi_write(8'h00, 32'h1, 4'h1, 0, 0);
        check("R3 start raised", 64'(core_start), 1);
        core_idle = 1'b0;
        axi_read(8'h00, "R6 busy read", 0);
        // R8 enable source, R7 global off
        axi_write(8'h08, 32'h1, 4'hF, 0, 0);
        pulse_done();
        check("R4 start dropped", 64'(core_start), 0);
        check("R7 irq masked by global", 64'(irq), 0);
        core_idle = 1'b1;
        axi_read(8'h0C, "R8 status set", 0);
        axi_read(8'h00, "R5 done seen", 0);
        axi_read(8'h00, "R5 done cleared", 0);
        axi_write(8'h04, 32'h1, 4'hF, 0, 0);
        check("R7 irq raised", 64'(irq), 1);
        axi_read(8'h04, "R7 global readback", 0);
        axi_write(8'h0C, 32'h1, 4'hF, 1, 0);
        check("R8 status cleared irq", 64'(irq), 0);
        axi_read(8'h0C, "R8 status cleared", 0);
        // R8 source disabled
        axi_write(8'h08, 32'h0, 4'hF, 0, 0);
        axi_write(8'h00, 32'h1, 4'hF, 0, 0);
        pulse_done();
        check("R8 no status when disabled", 64'(irq), 0);
        axi_read(8'h0C, "R8 status stays clear", 0);
        axi_read(8'h00, "R5 done flag", 3);
        // enabled with global on, irq from completion
        axi_write(8'h08, 32'h1, 4'hF, 2, 0);
        axi_write(8'h00, 32'h1, 4'hF, 1, 1);
        step();
        pulse_done();
        check("R7 irq on completion", 64'(irq), 1);
        check("R4 start low after done", 64'(core_start), 0);
        axi_read(8'h00, "R5 done read", 0);
        axi_write(8'h04, 32'h0, 4'hF, 0, 0);
        check("R7 irq off with global clear", 64'(irq), 0);
        repeat (3) step();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule